// File: doc/BRIEF.md
# Disk DMA Transfer Mode Selector

This block picks the fastest DMA transfer mode that both an attached storage drive and the host controller support. The result is capped by a mode that software asks for. Each request is one strobe, and the inputs are sampled together with it. These inputs are:
- the requested mode code;
- the drive's identify information: the validity flags, the three support words (ultra, multiword, single-word) and the legacy timing word;
- the host's capability mask for each class of mode;
- the cable detect flag;
- the media type, and a host policy bit that bars DMA for non-disk devices.

One clock later the block presents a registered 8-bit mode code together with a one-cycle valid pulse.

The mode codes are: ultra DMA n = 0x40 + n, multiword DMA n = 0x20 + n, single-word DMA n = 0x10 + n, and 0 = no DMA. The three classes are searched from fastest to slowest. A class only takes part if the requested mode is at or above that class's base code. The block only chooses a code. Setting up any timing registers is left to the logic that consumes that code.

Top module: `xfer_mode_select`

## Requirements
- R1: Classes are examined in priority order: ultra (base 0x40), then multiword (base 0x20), then single-word (base 0x10). A class is skipped when reqMode is below its base. The first class not skipped that has a nonzero mask decides the mode: its base plus the bit index of the highest set bit of its mask.
- R2: The ultra mask is hostUltraMask AND the low byte of driveUltra. It is zero unless bit 2 of idValid is set.
- R3: The fast-ultra clamp applies when all three of these hold: reqMode is greater than 0x42, the ultra mask has any of bits 3..6 set, and cable80 is low. The ultra mask is then cut down to its bits 2..0. With reqMode at or below 0x42, or with cable80 high, the mask is not clamped.
- R4: The multiword mask is hostMwMask AND the low byte of driveMword. It is zero unless bit 1 of idValid is set.
- R5: When bit 1 of idValid is set, the single-word mask is the low byte of driveSword AND hostSwMask.
- R6: When bit 1 of idValid is clear, the single-word mask comes from the low byte v of legacyTiming. If v is at most 2, the mask is ((2 << v) - 1) AND hostSwMask. If v is above 2, the mask is zero.
- R7: When nonDisk and noDmaNonDisk are both high, the result is 0, whatever the other inputs are.
- R8: The result is never above reqMode: it is the smaller of the selected mode and reqMode.
- R9: modeValid pulses high exactly one cycle after each cycle with reqValid high, and is low otherwise. After reset, modeValid and modeOut are 0. modeOut holds its value between requests.
- R10: If no eligible class has a nonzero mask, the result is 0, and modeValid is still asserted.
- R11: Only bits 7..0 of driveUltra, driveMword, driveSword and legacyTiming are used. Their upper bits have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe; all other inputs are sampled with it |
| reqMode | input | 8 | Requested upper limit mode code |
| idValid | input | 3 | Identify validity flags (bit 1 = multi/single words, bit 2 = ultra word) |
| driveUltra | input | 16 | Drive ultra DMA support word |
| driveMword | input | 16 | Drive multiword DMA support word |
| driveSword | input | 16 | Drive single-word DMA support word |
| legacyTiming | input | 16 | Drive legacy single-word timing word |
| hostUltraMask | input | 8 | Host ultra DMA capability mask |
| hostMwMask | input | 8 | Host multiword DMA capability mask |
| hostSwMask | input | 8 | Host single-word DMA capability mask |
| cable80 | input | 1 | 80-wire cable detected |
| nonDisk | input | 1 | Device is not a disk |
| noDmaNonDisk | input | 1 | Host forbids DMA for non-disk devices |
| modeOut | output | 8 | Selected mode code (0 = no DMA) |
| modeValid | output | 1 | One-cycle result strobe |

## Verification
The hardest case to reach is the cable clamp wiping out the ultra class. In that case the search must fall through to the multiword class, and the clamp must not fire when the request sits exactly at ultra mode 2. The stimulus sets up a drive whose ultra support has only bits 3..6 set and that also reports multiword modes. It then runs that drive with the cable absent, at requests just above and exactly at 0x42, so that each possible wrong behaviour gives a different code. A stream of random identify words, masks and requests then follows, compared against a model that the bench builds from the requirements.

// File: rtl/xms_pkg.sv
package xms_pkg;
  localparam int NUM_CLASS = 3;
  // Priority order: index 0 is searched first.
  localparam logic [7:0] CLASS_BASE [NUM_CLASS] = '{8'h40, 8'h20, 8'h10};
  localparam logic [7:0] ULTRA_CLAMP_ABOVE = 8'h42;
  localparam logic [7:0] FAST_ULTRA_BITS   = 8'h78;
  localparam logic [7:0] SLOW_ULTRA_BITS   = 8'h07;
  localparam logic [7:0] LEGACY_MAX        = 8'd2;

  typedef struct packed {
    logic load;
  } xmsStrobe_t;
endpackage

// File: rtl/xms_ctrl.sv
module xms_ctrl
  import xms_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output xmsStrobe_t strobe,
  output logic       modeValid
);
  always_comb strobe.load = reqValid;

  always_ff @(posedge clk) begin
    if (!rstN) modeValid <= 1'b0;
    else       modeValid <= reqValid;
  end
endmodule

// File: rtl/xms_datapath.sv
module xms_datapath
  import xms_pkg::*;
#(
  parameter int MODE_W = 8,
  parameter int MASK_W = 8,
  parameter int ID_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  xmsStrobe_t        strobe,
  input  logic [MODE_W-1:0] reqMode,
  input  logic [2:0]        idValid,
  input  logic [ID_W-1:0]   driveUltra,
  input  logic [ID_W-1:0]   driveMword,
  input  logic [ID_W-1:0]   driveSword,
  input  logic [ID_W-1:0]   legacyTiming,
  input  logic [MASK_W-1:0] hostUltraMask,
  input  logic [MASK_W-1:0] hostMwMask,
  input  logic [MASK_W-1:0] hostSwMask,
  input  logic              cable80,
  input  logic              nonDisk,
  input  logic              noDmaNonDisk,
  output logic [MODE_W-1:0] modeOut
);
  localparam int IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;

  function automatic logic [IDX_W-1:0] topBit(input logic [MASK_W-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < MASK_W; i++)
      if (m[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic [MASK_W-1:0] classMask [NUM_CLASS];
  logic [NUM_CLASS-1:0] classHit;
  logic [MODE_W-1:0] classMode [NUM_CLASS];
  logic [MASK_W-1:0] ultraRaw, legacyMask;
  logic [7:0]        legacyVal;
  logic [MODE_W-1:0] chosen, limited;

  // ultra class
  always_comb begin
    ultraRaw = idValid[2] ? (hostUltraMask & driveUltra[MASK_W-1:0]) : '0;
    classMask[0] = ultraRaw;
    if ((reqMode > MODE_W'(ULTRA_CLAMP_ABOVE)) && !cable80 &&
        |(ultraRaw & MASK_W'(FAST_ULTRA_BITS)))
      classMask[0] = ultraRaw & MASK_W'(SLOW_ULTRA_BITS);
  end

  // multiword class
  always_comb
    classMask[1] = idValid[1] ? (hostMwMask & driveMword[MASK_W-1:0]) : '0;

  // single-word class, with legacy timing fallback
  always_comb begin
    legacyVal  = legacyTiming[7:0];
    legacyMask = '0;
    if (legacyVal <= LEGACY_MAX)
      legacyMask = (MASK_W'(2) << legacyVal[1:0]) - MASK_W'(1);
    classMask[2] = idValid[1] ? (driveSword[MASK_W-1:0] & hostSwMask)
                              : (legacyMask & hostSwMask);
  end

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
    always_comb begin
      classHit[c]  = (reqMode >= MODE_W'(CLASS_BASE[c])) && (|classMask[c]);
      classMode[c] = MODE_W'(CLASS_BASE[c]) + MODE_W'(topBit(classMask[c]));
    end
  end

  always_comb begin
    chosen = '0;
    for (int c = NUM_CLASS - 1; c >= 0; c--)
      if (classHit[c]) chosen = classMode[c];
    if (nonDisk && noDmaNonDisk) chosen = '0;
    limited = (chosen < reqMode) ? chosen : reqMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            modeOut <= '0;
    else if (strobe.load) modeOut <= limited;
  end
endmodule

// File: rtl/xfer_mode_select.sv
module xfer_mode_select
  import xms_pkg::*;
#(
  parameter int MODE_W = 8,
  parameter int MASK_W = 8,
  parameter int ID_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [MODE_W-1:0] reqMode,
  input  logic [2:0]        idValid,
  input  logic [ID_W-1:0]   driveUltra,
  input  logic [ID_W-1:0]   driveMword,
  input  logic [ID_W-1:0]   driveSword,
  input  logic [ID_W-1:0]   legacyTiming,
  input  logic [MASK_W-1:0] hostUltraMask,
  input  logic [MASK_W-1:0] hostMwMask,
  input  logic [MASK_W-1:0] hostSwMask,
  input  logic              cable80,
  input  logic              nonDisk,
  input  logic              noDmaNonDisk,
  output logic [MODE_W-1:0] modeOut,
  output logic              modeValid
);
  xmsStrobe_t strobe;

  xms_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .strobe(strobe), .modeValid(modeValid)
  );

  xms_datapath #(.MODE_W(MODE_W), .MASK_W(MASK_W), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqMode(reqMode),
    .idValid(idValid), .driveUltra(driveUltra), .driveMword(driveMword),
    .driveSword(driveSword), .legacyTiming(legacyTiming),
    .hostUltraMask(hostUltraMask), .hostMwMask(hostMwMask),
    .hostSwMask(hostSwMask), .cable80(cable80), .nonDisk(nonDisk),
    .noDmaNonDisk(noDmaNonDisk), .modeOut(modeOut)
  );
endmodule

// File: rtl/xms_checker.sv
module xms_checker #(
  parameter int MODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [MODE_W-1:0] reqMode,
  input logic              nonDisk,
  input logic              noDmaNonDisk,
  input logic [MODE_W-1:0] modeOut,
  input logic              modeValid
);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> modeValid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !modeValid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(modeOut));

  a_r8_cap: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (modeOut <= $past(reqMode)));

  a_r7_forbid: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && nonDisk && noDmaNonDisk) |=> (modeOut == '0));

  a_r1_code_form: assert property (@(posedge clk) disable iff (!rstN)
    (modeValid && modeOut != '0) |->
      ($onehot0(modeOut[MODE_W-1:4]) && modeOut[MODE_W-1:4] != '0));
endmodule

bind xfer_mode_select xms_checker #(.MODE_W(MODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
  .nonDisk(nonDisk), .noDmaNonDisk(noDmaNonDisk),
  .modeOut(modeOut), .modeValid(modeValid)
);

// File: tb/test_xfer_mode_select.sv
module test_xfer_mode_select;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [7:0] reqMode = '0;
  logic [2:0] idValid = '0;
  logic [15:0] driveUltra = '0, driveMword = '0, driveSword = '0, legacyTiming = '0;
  logic [7:0] hostUltraMask = '0, hostMwMask = '0, hostSwMask = '0;
  logic cable80 = 1'b0, nonDisk = 1'b0, noDmaNonDisk = 1'b0;
  logic [7:0] modeOut;
  logic modeValid;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] mode;
    string      tag;
  } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;

  xfer_mode_select i_xfer_mode_select (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .idValid(idValid), .driveUltra(driveUltra), .driveMword(driveMword),
    .driveSword(driveSword), .legacyTiming(legacyTiming),
    .hostUltraMask(hostUltraMask), .hostMwMask(hostMwMask),
    .hostSwMask(hostSwMask), .cable80(cable80), .nonDisk(nonDisk),
    .noDmaNonDisk(noDmaNonDisk), .modeOut(modeOut), .modeValid(modeValid)
  );

  function automatic int highest(input logic [7:0] m);
    for (int i = 7; i >= 0; i--) if (m[i]) return i;
    return -1;
  endfunction

  // Reference model written from the requirements.
  function automatic logic [7:0] model();
    logic [7:0] um, mm, sm, res;
    um = 8'h00; mm = 8'h00; sm = 8'h00; res = 8'h00;
    if (idValid[2]) um = hostUltraMask & driveUltra[7:0];          // R2
    if (reqMode > 8'h42 && (um & 8'h78) != 0 && !cable80) um &= 8'h07; // R3
    if (idValid[1]) mm = hostMwMask & driveMword[7:0];             // R4
    if (idValid[1]) sm = driveSword[7:0] & hostSwMask;             // R5
    else if (legacyTiming[7:0] <= 2)
      sm = ((8'd2 << legacyTiming[7:0]) - 8'd1) & hostSwMask;      // R6
    if (reqMode >= 8'h40 && um != 0) res = 8'h40 + 8'(highest(um)); // R1
    else if (reqMode >= 8'h20 && mm != 0) res = 8'h20 + 8'(highest(mm));
    else if (reqMode >= 8'h10 && sm != 0) res = 8'h10 + 8'(highest(sm));
    if (nonDisk && noDmaNonDisk) res = 8'h00;                      // R7
    if (res > reqMode) res = reqMode;                              // R8
    return res;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [7:0] rq, input logic [2:0] vf,
                       input logic [15:0] du, input logic [15:0] dm, input logic [15:0] ds,
                       input logic [15:0] lt, input logic [7:0] hu, input logic [7:0] hm,
                       input logic [7:0] hs, input logic cab, input logic nd, input logic fb);
    item_t it;
    @(negedge clk);
    reqMode = rq; idValid = vf; driveUltra = du; driveMword = dm; driveSword = ds;
    legacyTiming = lt; hostUltraMask = hu; hostMwMask = hm; hostSwMask = hs;
    cable80 = cab; nonDisk = nd; noDmaNonDisk = fb; reqValid = 1'b1;
    it.mode = model(); it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic expectMode(input string tag, input logic [7:0] exp,
                            input logic [7:0] rq, input logic [2:0] vf,
                            input logic [15:0] du, input logic [15:0] dm, input logic [15:0] ds,
                            input logic [15:0] lt, input logic [7:0] hu, input logic [7:0] hm,
                            input logic [7:0] hs, input logic cab, input logic nd, input logic fb);
    apply(tag, rq, vf, du, dm, ds, lt, hu, hm, hs, cab, nd, fb);
    check(sbq[$].mode == exp, {tag, " (model)"}, sbq[$].mode, exp);
  endtask

  // Monitor: pops and compares on every result strobe.
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && modeValid) begin
        if (sbq.size() == 0) check(1'b0, "R9 unexpected valid", 1, 0);
        else begin
          item_t it;
          it = sbq.pop_front();
          check(modeOut == it.mode, it.tag, modeOut, it.mode);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(modeValid == 1'b0, "R9 reset valid", modeValid, 0);
    check(modeOut == 8'h00, "R9 reset mode", modeOut, 0);
    rstN = 1'b1;

    // Directed cases: tag, expected, req, valid, dU, dM, dS, tim, hU, hM, hS, cab, nd, fb
    expectMode("R1 R2 ultra top",        8'h46, 8'h46, 3'b110, 16'h007F, 16'h0007, 16'h0007, 16'h0, 8'h7F, 8'h07, 8'h07, 1, 0, 0);
    expectMode("R2 host gates ultra",    8'h42, 8'h46, 3'b110, 16'h007F, 16'h0007, 16'h0007, 16'h0, 8'h07, 8'h07, 8'h07, 1, 0, 0);
    expectMode("R3 clamp no cable",      8'h42, 8'h46, 3'b110, 16'h007F, 16'h0007, 16'h0007, 16'h0, 8'h7F, 8'h07, 8'h07, 0, 0, 0);
    expectMode("R3 clamp empties ultra", 8'h22, 8'h43, 3'b110, 16'h0078, 16'h0007, 16'h0007, 16'h0, 8'h7F, 8'h07, 8'h07, 0, 0, 0);
    expectMode("R3 no clamp at 0x42",    8'h42, 8'h42, 3'b110, 16'h0078, 16'h0007, 16'h0007, 16'h0, 8'h7F, 8'h07, 8'h07, 0, 0, 0);
    expectMode("R2 ultra invalid",       8'h22, 8'h46, 3'b010, 16'h007F, 16'h0007, 16'h0007, 16'h0, 8'h7F, 8'h07, 8'h07, 1, 0, 0);
    expectMode("R1 ultra skipped",       8'h22, 8'h3F, 3'b110, 16'h007F, 16'h0007, 16'h0007, 16'h0, 8'h7F, 8'h07, 8'h07, 1, 0, 0);
    expectMode("R8 cap to request",      8'h21, 8'h21, 3'b110, 16'h007F, 16'h0007, 16'h0007, 16'h0, 8'h7F, 8'h07, 8'h07, 1, 0, 0);
    expectMode("R4 host gates mword",    8'h21, 8'h46, 3'b010, 16'h0000, 16'h0007, 16'h0007, 16'h0, 8'h00, 8'h03, 8'h07, 1, 0, 0);
    expectMode("R5 single word",         8'h12, 8'h1F, 3'b110, 16'h007F, 16'h0007, 16'h0007, 16'h0, 8'h7F, 8'h07, 8'h07, 1, 0, 0);
    expectMode("R6 legacy timing 1",     8'h11, 8'h46, 3'b100, 16'h0000, 16'h0007, 16'h0007, 16'h0001, 8'h7F, 8'h07, 8'h07, 1, 0, 0);
    expectMode("R6 legacy timing 3",     8'h00, 8'h46, 3'b000, 16'h0000, 16'h0007, 16'h0007, 16'h0003, 8'h7F, 8'h07, 8'h07, 1, 0, 0);
    expectMode("R11 legacy high byte",   8'h12, 8'h46, 3'b000, 16'h0000, 16'h0000, 16'h0000, 16'h0102, 8'h7F, 8'h07, 8'h07, 1, 0, 0);
    expectMode("R7 non-disk forbidden",  8'h00, 8'h46, 3'b110, 16'h007F, 16'h0007, 16'h0007, 16'h0, 8'h7F, 8'h07, 8'h07, 1, 1, 1);
    expectMode("R7 non-disk allowed",    8'h46, 8'h46, 3'b110, 16'h007F, 16'h0007, 16'h0007, 16'h0, 8'h7F, 8'h07, 8'h07, 1, 1, 0);
    expectMode("R11 ultra high byte",    8'h22, 8'h46, 3'b110, 16'hFF00, 16'hFF07, 16'h0007, 16'h0, 8'h7F, 8'h07, 8'h07, 1, 0, 0);
    expectMode("R10 nothing usable",     8'h00, 8'h46, 3'b000, 16'h007F, 16'h0007, 16'h0007, 16'h0005, 8'h7F, 8'h07, 8'h07, 1, 0, 0);
    expectMode("R10 request below sw",   8'h00, 8'h05, 3'b110, 16'h007F, 16'h0007, 16'h0007, 16'h0, 8'h7F, 8'h07, 8'h07, 1, 0, 0);

    // Idle: result must hold and no strobe.
    @(negedge clk);
    reqValid = 1'b0;
    reqMode = 8'h46; idValid = 3'b110; driveUltra = 16'h007F; hostUltraMask = 8'h7F;
    repeat (2) @(negedge clk);
    check(modeValid == 1'b0, "R9 idle no valid", modeValid, 0);
    check(modeOut == 8'h00, "R9 idle holds", modeOut, 0);

    // Random stream against the model.
    for (int n = 0; n < 300; n++) begin
      logic [7:0] rq;
      logic [2:0] vf;
      rq = 8'($urandom_range(0, 8'h4A));
      vf = 3'($urandom);
      apply("R1 random", rq, vf, 16'($urandom), 16'($urandom), 16'($urandom),
            16'($urandom_range(0, 4)), 8'($urandom), 8'($urandom), 8'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom));
      if (n % 7 == 3) begin
        @(negedge clk);
        reqValid = 1'b0;
      end
    end
    @(negedge clk);
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R9 all results seen", sbq.size(), 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule